// File: doc/BRIEF.md
# Frequent Value Compressed Cache

This block is a small direct-mapped data cache meant to sit next to a conventional direct-mapped cache. It keeps only words whose values belong to a table of ten frequently occurring 32-bit values. Each stored word is a 4-bit code that points into that table, so a whole line costs a few bits per word. Any single word can still be read or written on its own.

The processor side has one request port for reads and writes. A response comes back one cycle after each accepted request. A fill port installs a whole line of raw words. The words may come from the companion cache or from memory, and each word is encoded on the way in. A table write port loads the frequent values, and any table write drops every line.

With the default geometry the block has 64 lines of 8 words. That is 256 bytes of code storage plus tags, well below 3 Kbytes.

Top module: `fvc_cache`

## Requirements
- R1: After reset, `rsp_valid` and `rsp_hit` are low and every line is invalid, so the first read of any address misses.
- R2: A read hits when three things hold: the line at the index is valid, its tag matches, and the addressed word's code is 0 to 9. Then, one cycle after the request, `rsp_valid` and `rsp_hit` are high and `rsp_rdata` equals table entry number `code`.
- R3: A read to an invalid line or with a different tag gives `rsp_valid` high, `rsp_hit` low and `rsp_rdata` zero one cycle later.
- R4: A fill encodes every word on its own. A word that matches table entry i is stored as code i, and any other word gets the reserved code 15. A read of a code-15 word misses, while the other words of that line hit.
- R5: A fill writes the tag and all words of the line at its index and sets the line valid. Any line that held that index before is lost, so a read with the old tag misses.
- R6: A write whose tag hits stores the code of the new value. If the value is in the table, `rsp_hit` is high one cycle later and later reads return that value.
- R7: A write whose tag hits but whose value is not in the table stores code 15 and reports `rsp_hit` low. Later reads of that word miss, and the other words of the line keep their values.
- R8: A write whose tag misses changes nothing. It reports `rsp_hit` low, and the line at that index reads back as before.
- R9: A table write sets entry `tbl_idx` (0 to 9) to `tbl_value` and invalidates all lines.
- R10: Only one operation is taken per cycle. A table write goes first, then a fill, then a processor request. A request that is not taken is dropped, and `rsp_valid` stays low one cycle later.
- R11: Address bits [1:0] are a byte offset and are ignored. Bits [4:2] select the word, bits [10:5] are the index, and bits [31:11] are the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Write value |
| rsp_valid | output | 1 | Response to the request of the previous cycle |
| rsp_hit | output | 1 | Read hit, or write stored as a frequent value |
| rsp_rdata | output | 32 | Read value on a hit, zero otherwise |
| fill_valid | input | 1 | Install a line |
| fill_addr | input | 32 | Address of the line; word and byte bits are ignored |
| fill_data | input | 256 | Raw line words, word w at bits [32w+31:32w] |
| tbl_we | input | 1 | Table entry write |
| tbl_idx | input | 4 | Table entry number, 0 to 9 |
| tbl_value | input | 32 | New value for the entry |

## Verification
The main function is tried on one line that mixes frequent values with a value outside the table. A per-word hit then shows that each word is encoded on its own and is not judged as part of the whole line. Writes with values inside and outside the table, and writes with a tag that misses, separate re-encoding on a tag hit from leaving the line untouched. A second tag at the same index separates eviction from coexistence. Reloading a table entry, and repeating a read at several byte offsets, show that table writes invalidate the lines and that the address is split as R11 states. Operations issued in the same cycle show which one is taken and that the others are dropped.

// File: rtl/fvc_pkg.sv
package fvc_pkg;
  localparam int FV_COUNT = 10;
  localparam int CODE_W   = 4;
  localparam int WORD_W   = 32;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef word_t [FV_COUNT-1:0] fv_table_t;

  localparam code_t CODE_NONE = '1;

  // lowest matching entry wins; no match gives the reserved code
  function automatic code_t fv_encode(input word_t v, input fv_table_t t);
    code_t c;
    c = CODE_NONE;
    for (int i = FV_COUNT - 1; i >= 0; i--) begin
      if (t[i] == v) c = code_t'(i);
    end
    return c;
  endfunction

  function automatic logic fv_is_freq(input code_t c);
    return int'(c) < FV_COUNT;
  endfunction

  function automatic word_t fv_decode(input code_t c, input fv_table_t t);
    word_t v;
    v = '0;
    for (int i = 0; i < FV_COUNT; i++) begin
      if (int'(c) == i) v = t[i];
    end
    return v;
  endfunction
endpackage

// File: rtl/fvc_value_table.sv
module fvc_value_table
  import fvc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  code_t     wr_idx,
  input  word_t     wr_value,
  output fv_table_t table_q
);
  fv_table_t tab;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tab <= '0;
    end else if (wr_en && fv_is_freq(wr_idx)) begin
      for (int i = 0; i < FV_COUNT; i++) begin
        if (int'(wr_idx) == i) tab[i] <= wr_value;
      end
    end
  end

  assign table_q = tab;
endmodule

// File: rtl/fvc_encode_bank.sv
module fvc_encode_bank
  import fvc_pkg::*;
#(
  parameter int N = 8
) (
  input  fv_table_t     table_i,
  input  word_t [N-1:0] words,
  output code_t [N-1:0] codes
);
  for (genvar g = 0; g < N; g++) begin : g_enc
    assign codes[g] = fv_encode(words[g], table_i);
  end
endmodule

// File: rtl/fvc_line_store.sv
module fvc_line_store
  import fvc_pkg::*;
#(
  parameter int INDEX_W = 6,
  parameter int WSEL_W  = 3,
  parameter int TAG_W   = 21,
  localparam int LINES  = 1 << INDEX_W,
  localparam int WPL    = 1 << WSEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inval_all,
  input  logic               fill_en,
  input  logic [INDEX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0]   fill_tag,
  input  code_t [WPL-1:0]    fill_codes,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_idx,
  input  logic [WSEL_W-1:0]  wr_sel,
  input  code_t              wr_code,
  input  logic [INDEX_W-1:0] rd_idx,
  input  logic [WSEL_W-1:0]  rd_sel,
  output logic               rd_valid,
  output logic [TAG_W-1:0]   rd_tag,
  output code_t              rd_code,
  output logic [LINES-1:0]   line_valid
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q  [LINES];
  code_t            code_q [LINES][WPL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (inval_all) begin
      valid_q <= '0;
    end else if (fill_en) begin
      valid_q[fill_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx] <= fill_tag;
      for (int w = 0; w < WPL; w++) begin
        code_q[fill_idx][w] <= fill_codes[w];
      end
    end else if (wr_en) begin
      code_q[wr_idx][wr_sel] <= wr_code;
    end
  end

  assign rd_valid   = valid_q[rd_idx];
  assign rd_tag     = tag_q[rd_idx];
  assign rd_code    = code_q[rd_idx][rd_sel];
  assign line_valid = valid_q;
endmodule

// File: rtl/fvc_cache.sv
module fvc_cache
  import fvc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int INDEX_W = 6,
  parameter int WSEL_W  = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [WORD_W-1:0]            req_wdata,
  output logic                         rsp_valid,
  output logic                         rsp_hit,
  output logic [WORD_W-1:0]            rsp_rdata,
  input  logic                         fill_valid,
  input  logic [ADDR_W-1:0]            fill_addr,
  input  logic [(1<<WSEL_W)*WORD_W-1:0] fill_data,
  input  logic                         tbl_we,
  input  logic [CODE_W-1:0]            tbl_idx,
  input  logic [WORD_W-1:0]            tbl_value
);
  localparam int OFS_W  = $clog2(WORD_W / 8);
  localparam int WPL    = 1 << WSEL_W;
  localparam int LINES  = 1 << INDEX_W;
  localparam int IDX_LO = OFS_W + WSEL_W;
  localparam int TAG_LO = IDX_LO + INDEX_W;
  localparam int TAG_W  = ADDR_W - TAG_LO;

  // one operation per cycle: table, then fill, then request
  logic tbl_commit, fill_commit, req_accept;
  assign tbl_commit  = tbl_we;
  assign fill_commit = fill_valid && !tbl_we;
  assign req_accept  = req_valid && !tbl_we && !fill_valid;

  logic [INDEX_W-1:0] req_idx, fill_idx;
  logic [WSEL_W-1:0]  req_sel;
  logic [TAG_W-1:0]   req_tag, fill_tag;
  assign req_sel  = req_addr[IDX_LO-1:OFS_W];
  assign req_idx  = req_addr[TAG_LO-1:IDX_LO];
  assign req_tag  = req_addr[ADDR_W-1:TAG_LO];
  assign fill_idx = fill_addr[TAG_LO-1:IDX_LO];
  assign fill_tag = fill_addr[ADDR_W-1:TAG_LO];

  logic unused_addr_bits;
  assign unused_addr_bits = ^{req_addr[OFS_W-1:0], fill_addr[IDX_LO-1:0]};

  fv_table_t table_q;
  fvc_value_table u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tbl_commit),
    .wr_idx   (tbl_idx),
    .wr_value (tbl_value),
    .table_q  (table_q)
  );

  word_t [WPL-1:0] fill_words;
  code_t [WPL-1:0] fill_codes;
  assign fill_words = fill_data;

  fvc_encode_bank #(.N(WPL)) u_fill_enc (
    .table_i (table_q),
    .words   (fill_words),
    .codes   (fill_codes)
  );

  word_t [0:0] wr_words;
  code_t [0:0] wr_codes;
  assign wr_words[0] = req_wdata;

  fvc_encode_bank #(.N(1)) u_wr_enc (
    .table_i (table_q),
    .words   (wr_words),
    .codes   (wr_codes)
  );

  logic               rd_valid;
  logic [TAG_W-1:0]   rd_tag;
  code_t              rd_code;
  logic [LINES-1:0]   line_valid;
  logic               tag_match, lookup_hit, wr_commit, wr_hit;

  assign tag_match  = rd_valid && (rd_tag == req_tag);
  assign lookup_hit = tag_match && fv_is_freq(rd_code);
  assign wr_commit  = req_accept && req_write && tag_match;
  assign wr_hit     = wr_commit && fv_is_freq(wr_codes[0]);

  fvc_line_store #(
    .INDEX_W (INDEX_W),
    .WSEL_W  (WSEL_W),
    .TAG_W   (TAG_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .inval_all  (tbl_commit),
    .fill_en    (fill_commit),
    .fill_idx   (fill_idx),
    .fill_tag   (fill_tag),
    .fill_codes (fill_codes),
    .wr_en      (wr_commit),
    .wr_idx     (req_idx),
    .wr_sel     (req_sel),
    .wr_code    (wr_codes[0]),
    .rd_idx     (req_idx),
    .rd_sel     (req_sel),
    .rd_valid   (rd_valid),
    .rd_tag     (rd_tag),
    .rd_code    (rd_code),
    .line_valid (line_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_accept;
      rsp_hit   <= req_accept && (req_write ? wr_hit : lookup_hit);
      rsp_rdata <= (req_accept && !req_write && lookup_hit)
                   ? fv_decode(rd_code, table_q) : '0;
    end
  end
endmodule

// File: rtl/fvc_cache_checker.sv
module fvc_cache_checker #(
  parameter int LINES = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tbl_we,
  input logic             fill_valid,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [31:0]      rsp_rdata,
  input logic             req_accept,
  input logic             fill_commit,
  input logic             tbl_commit,
  input logic             wr_commit,
  input logic             tag_match,
  input logic [LINES-1:0] line_valid
);
  a_r10_table_first: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> (!fill_commit && !req_accept));
  a_r10_fill_before_req: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> !req_accept);
  a_r10_no_rsp_when_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    !req_accept |=> !rsp_valid);
  a_r2_rsp_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> rsp_valid);
  a_r1_hit_needs_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);
  a_r3_miss_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_rdata == '0));
  a_r9_table_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_commit |=> (line_valid == '0));
  a_r8_write_needs_tag: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> tag_match);
  a_r5_fill_marks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fill_commit |=> (line_valid != '0));
endmodule

bind fvc_cache fvc_cache_checker #(.LINES(LINES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tbl_we      (tbl_we),
  .fill_valid  (fill_valid),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .rsp_rdata   (rsp_rdata),
  .req_accept  (req_accept),
  .fill_commit (fill_commit),
  .tbl_commit  (tbl_commit),
  .wr_commit   (wr_commit),
  .tag_match   (tag_match),
  .line_valid  (line_valid)
);

// File: tb/fvc_cache_bench.sv
module fvc_cache_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [31:0]  req_addr = '0, req_wdata = '0;
  logic         rsp_valid, rsp_hit;
  logic [31:0]  rsp_rdata;
  logic         fill_valid = 1'b0;
  logic [31:0]  fill_addr = '0;
  logic [255:0] fill_data = '0;
  logic         tbl_we = 1'b0;
  logic [3:0]   tbl_idx = '0;
  logic [31:0]  tbl_value = '0;

  always #5 clk = ~clk;

  fvc_cache u_fvc_cache (.*);

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model: raw words per line
  logic [31:0] mtab [10];
  bit          mv   [64];
  logic [20:0] mtag [64];
  logic [31:0] mword [64][8];

  function automatic bit ref_freq(input logic [31:0] v);
    for (int i = 0; i < 10; i++) if (mtab[i] == v) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] mk(input logic [20:0] tg, input int idx, input int ws);
    return {tg, 6'(idx), 3'(ws), 2'b00};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_tbl(input int idx, input logic [31:0] val);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 4'(idx); tbl_value = val;
    @(posedge clk); #1;
    tbl_we = 1'b0;
    mtab[idx] = val;
    for (int i = 0; i < 64; i++) mv[i] = 1'b0;
  endtask

  task automatic do_fill(input logic [31:0] addr, input logic [255:0] data);
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = addr; fill_data = data;
    @(posedge clk); #1;
    fill_valid = 1'b0;
    mv[addr[10:5]] = 1'b1;
    mtag[addr[10:5]] = addr[31:11];
    for (int w = 0; w < 8; w++) mword[addr[10:5]][w] = data[w*32 +: 32];
  endtask

  task automatic do_read(input logic [31:0] addr, input string req);
    bit eh;
    logic [31:0] ed;
    int idx = int'(addr[10:5]);
    int ws  = int'(addr[4:2]);
    eh = mv[idx] && mtag[idx] == addr[31:11] && ref_freq(mword[idx][ws]);
    ed = eh ? mword[idx][ws] : 32'h0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = addr;
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, req, "read rsp_valid", 32'(rsp_valid), 32'h1);
    chk(rsp_hit == eh, req, "read rsp_hit", 32'(rsp_hit), 32'(eh));
    chk(rsp_rdata == ed, req, "read rsp_rdata", rsp_rdata, ed);
  endtask

  task automatic do_write(input logic [31:0] addr, input logic [31:0] val, input string req);
    bit th, eh;
    int idx = int'(addr[10:5]);
    int ws  = int'(addr[4:2]);
    th = mv[idx] && mtag[idx] == addr[31:11];
    eh = th && ref_freq(val);
    if (th) mword[idx][ws] = val;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = addr; req_wdata = val;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
    chk(rsp_valid == 1'b1, req, "write rsp_valid", 32'(rsp_valid), 32'h1);
    chk(rsp_hit == eh, req, "write rsp_hit", 32'(rsp_hit), 32'(eh));
  endtask

  localparam logic [20:0] TA = 21'h00123, TB = 21'h1ABCD, TC = 21'h00077;

  function automatic logic [255:0] line_a();
    logic [255:0] d;
    d[0*32 +: 32] = 32'h0000_0010; d[1*32 +: 32] = 32'hDEAD_BEEF;
    d[2*32 +: 32] = 32'h1234_5678; d[3*32 +: 32] = 32'h0000_0000;
    d[4*32 +: 32] = 32'hFFFF_FFFF; d[5*32 +: 32] = 32'hA5A5_A5A5;
    d[6*32 +: 32] = 32'h0000_0003; d[7*32 +: 32] = 32'h0000_0064;
    return d;
  endfunction

  task automatic t_reset();
    chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", 32'(rsp_valid), 32'h0);
    chk(rsp_hit == 1'b0, "R1", "reset rsp_hit", 32'(rsp_hit), 32'h0);
    do_read(mk(21'h0, 0, 0), "R1");
  endtask

  task automatic t_load();
    logic [31:0] v [10] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h10, 32'h20,
                             32'h8000_0000, 32'hDEAD_BEEF, 32'h64, 32'h3, 32'hA5A5_A5A5};
    for (int i = 0; i < 10; i++) do_tbl(i, v[i]);
  endtask

  task automatic t_mixed_line();
    do_fill(mk(TA, 3, 0), line_a());
    for (int w = 0; w < 8; w++) do_read(mk(TA, 3, w), (w == 2) ? "R4" : "R2");
  endtask

  task automatic t_misses();
    do_read(mk(TB, 3, 0), "R3");
    do_read(mk(TA, 9, 0), "R3");
  endtask

  task automatic t_writes();
    do_write(mk(TA, 3, 2), 32'h20, "R6");
    do_read(mk(TA, 3, 2), "R6");
    do_write(mk(TA, 3, 1), 32'hCAFE_0000, "R7");
    do_read(mk(TA, 3, 1), "R7");
    do_read(mk(TA, 3, 0), "R7");
    do_write(mk(TB, 3, 0), 32'h1, "R8");
    do_read(mk(TA, 3, 0), "R8");
    do_read(mk(TB, 3, 0), "R8");
  endtask

  task automatic t_offsets();
    do_read(mk(TA, 3, 0) | 32'h1, "R11");
    do_read(mk(TA, 3, 4) | 32'h3, "R11");
  endtask

  task automatic t_conflict();
    logic [255:0] d;
    for (int w = 0; w < 8; w++) d[w*32 +: 32] = 32'(w);
    do_fill(mk(TB, 3, 0), d);
    do_read(mk(TA, 3, 0), "R5");
    do_read(mk(TB, 3, 1), "R5");
    do_read(mk(TB, 3, 3), "R5");
    do_read(mk(TB, 3, 5), "R5");
  endtask

  task automatic t_reload();
    logic [255:0] d;
    do_tbl(3, 32'h11);
    do_read(mk(TB, 3, 1), "R9");
    d = line_a();
    d[0*32 +: 32] = 32'h11;
    d[1*32 +: 32] = 32'h10;
    do_fill(mk(TA, 3, 0), d);
    do_read(mk(TA, 3, 0), "R9");
    do_read(mk(TA, 3, 1), "R9");
  endtask

  task automatic t_priority();
    logic [255:0] d;
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 4'd3; tbl_value = 32'h10;
    req_valid = 1'b1; req_write = 1'b0; req_addr = mk(TA, 3, 0);
    @(posedge clk); #1;
    tbl_we = 1'b0; req_valid = 1'b0;
    mtab[3] = 32'h10;
    for (int i = 0; i < 64; i++) mv[i] = 1'b0;
    chk(rsp_valid == 1'b0, "R10", "dropped read rsp_valid", 32'(rsp_valid), 32'h0);
    do_fill(mk(TA, 3, 0), line_a());
    for (int w = 0; w < 8; w++) d[w*32 +: 32] = 32'h64;
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = mk(TC, 7, 0); fill_data = d;
    req_valid = 1'b1; req_write = 1'b1; req_addr = mk(TA, 3, 0); req_wdata = 32'h1;
    @(posedge clk); #1;
    fill_valid = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    mv[7] = 1'b1; mtag[7] = TC;
    for (int w = 0; w < 8; w++) mword[7][w] = 32'h64;
    chk(rsp_valid == 1'b0, "R10", "dropped write rsp_valid", 32'(rsp_valid), 32'h0);
    do_read(mk(TA, 3, 0), "R10");
    do_read(mk(TC, 7, 6), "R10");
  endtask

  initial begin
    for (int i = 0; i < 10; i++) mtab[i] = 32'h0;
    for (int i = 0; i < 64; i++) begin
      mv[i] = 1'b0; mtag[i] = '0;
      for (int w = 0; w < 8; w++) mword[i][w] = 32'h0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_mixed_line();
    t_misses();
    t_writes();
    t_offsets();
    t_conflict();
    t_reload();
    t_priority();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule